// File: doc/BRIEF.md
# Dual Timer with Capture/Reload

This block holds two 16-bit timers that share one capture/reload register. The core timer counts prescaled system-clock ticks in either direction. Each time it wraps past either end of its range, it flips an output latch and raises a one-cycle wrap pulse. If reload is enabled, it also loads itself from the shared register. The auxiliary timer counts either its own prescaled ticks or the transitions of that latch. On a chosen edge of an external event, its value is copied into the shared register and, optionally, the timer is cleared.

Together the two timers can measure intervals or multiply a pulse rate with no software involved. The auxiliary timer measures the interval between events and stores it in the shared register. The core timer reloads from that register and so repeats the same period, with the latch as its output.

Software writes control and count values through a simple write port. The count, capture and latch state appear directly on output ports.

Top module: `dual_timer_cr`

## Requirements
- R1: Each timer has a 3-bit prescaler code k in bits [2:0] of its control word and a run bit in bit 3. A running timer steps once every 2^(k+2) system clocks, so it advances by exactly n over any span of n·2^(k+2) clocks.
- R2: Counts are 16 bits. Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Either step is a wrap of that timer.
- R3: Control bit 4 selects down counting. When control bit 5 is set, a high level on that timer's synchronized direction pin inverts the chosen direction.
- R4: On every wrap of the core timer, the latch output inverts and wrap_pulse is high for exactly that one cycle. At all other times the latch holds its value.
- R5: When core control bit 6 is set, a core wrap loads the core timer from the capture/reload register instead of stepping.
- R6: When auxiliary control bit 6 is set, the running auxiliary timer steps once per core-timer wrap (that is, once per latch transition) instead of on prescaled ticks.
- R7: Auxiliary control bits [8:7] choose the capture edge: 00 off, 01 rising, 10 falling, 11 both. A matching edge copies the auxiliary count into the capture/reload register on the third clock edge after the pin changes. Edges that do not match are ignored.
- R8: When auxiliary control bit 9 is set, a capture also clears the auxiliary timer to zero.
- R9: Auxiliary control bits [11:10] choose the capture source: 00 the capture pin, 01 alternate input A, 10 alternate input B, 11 an edge on either alternate input.
- R10: If a capture and a core reload fall in the same cycle, the register takes the captured value and the core timer loads the value the register held before that cycle.
- R11: The write addresses are: 0 core control, 1 auxiliary control, 2 core count, 3 auxiliary count, 4 capture/reload. A write to a count register takes effect in place of any count, reload or clear in that same cycle.
- R12: After reset, both counts, the capture/reload register, the latch and wrap_pulse are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| dir_core_pin | input | 1 | External direction input, core timer |
| dir_aux_pin | input | 1 | External direction input, auxiliary timer |
| cap_pin | input | 1 | Capture event input |
| alt_a_pin | input | 1 | Alternate capture source A |
| alt_b_pin | input | 1 | Alternate capture source B |
| core_cnt | output | 16 | Core timer count |
| aux_cnt | output | 16 | Auxiliary timer count |
| caprel | output | 16 | Capture/reload register |
| latch_out | output | 1 | Toggle latch output |
| wrap_pulse | output | 1 | One-cycle pulse on each core wrap |

## Verification
A register write takes effect at the clock edge on which it is presented. A capture lands on the third edge after the pin changes: two synchronizer stages, then the register itself. The bench therefore waits at least four cycles after moving a pin before it samples. Counting is measured from the edge that starts a timer to the edge that stops it, and the span is made a whole multiple of the prescale divisor, so the expected count does not depend on prescaler phase. The same-cycle cases lock onto an observed wrap pulse. They then place the capture edge or the count write exactly four edges later, where the next reload falls.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int CNT_W   = 16;
    localparam int CODE_W  = 3;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] A_CORE_CTL = 3'd0;
    localparam logic [ADDR_W-1:0] A_AUX_CTL  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CORE_CNT = 3'd2;
    localparam logic [ADDR_W-1:0] A_AUX_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAPREL   = 3'd4;

    typedef struct packed {
        logic              reload;
        logic              pin_en;
        logic              down;
        logic              run;
        logic [CODE_W-1:0] presc;
    } core_ctl_t;

    typedef struct packed {
        logic [1:0]        src;
        logic              clr;
        logic [1:0]        edge_sel;
        logic              on_latch;
        logic              pin_en;
        logic              down;
        logic              run;
        logic [CODE_W-1:0] presc;
    } aux_ctl_t;

    localparam int CC_W = $bits(core_ctl_t);
    localparam int AC_W = $bits(aux_ctl_t);

    typedef struct packed {
        core_ctl_t        cc;
        aux_ctl_t         ac;
        logic [CNT_W-1:0] core;
        logic [CNT_W-1:0] aux;
        logic [CNT_W-1:0] cr;
        logic             latch;
        logic             wrap;
    } tmr_state_t;
endpackage

// File: rtl/gpt_presc.sv
module gpt_presc #(
    parameter int NT         = 2,
    parameter int CODE_W     = 3,
    parameter int BASE_SHIFT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NT-1:0][CODE_W-1:0]    code,
    output logic [NT-1:0]                tick
);
    localparam int PW = BASE_SHIFT + (1 << CODE_W) - 1;

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar i = 0; i < NT; i++) begin : g_tick
        logic [PW-1:0] mask;
        always_comb begin
            mask    = (PW'(1) << (int'(code[i]) + BASE_SHIFT)) - PW'(1);
            tick[i] = &(div_q | ~mask);
        end
    end
endmodule

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] sync
);
    logic [N-1:0] st1_q, st2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st1_q <= '0;
            st2_q <= '0;
        end else begin
            st1_q <= pin;
            st2_q <= st1_q;
        end
    end

    assign sync = st2_q;
endmodule

// File: rtl/gpt_edge.sv
module gpt_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] cur, prev_q;

    gpt_sync #(.N(N)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (pin),
        .sync (cur)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur;
    end

    assign rise = cur & ~prev_q;
    assign fall = ~cur & prev_q;
endmodule

// File: rtl/dual_timer_cr.sv
module dual_timer_cr
    import gpt_pkg::*;
#(
    parameter int BASE_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              dir_core_pin,
    input  logic              dir_aux_pin,
    input  logic              cap_pin,
    input  logic              alt_a_pin,
    input  logic              alt_b_pin,
    output logic [CNT_W-1:0]  core_cnt,
    output logic [CNT_W-1:0]  aux_cnt,
    output logic [CNT_W-1:0]  caprel,
    output logic              latch_out,
    output logic              wrap_pulse
);
    tmr_state_t s_d, s_q;

    logic [1:0][CODE_W-1:0] codes;
    logic [1:0]             tick;
    logic [1:0]             dir_sy;
    logic [2:0]             ev_rise, ev_fall;

    logic wr_cc, wr_ac, wr_core, wr_aux, wr_cr;
    logic core_down, aux_down, core_step, core_wrap, aux_step;
    logic sel_rise, sel_fall, cap_evt;
    logic chk_reload, chk_clr;

    assign codes = {s_q.ac.presc, s_q.cc.presc};

    gpt_presc #(.NT(2), .CODE_W(CODE_W), .BASE_SHIFT(BASE_SHIFT)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .code (codes),
        .tick (tick)
    );

    gpt_sync #(.N(2)) u_dir_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({dir_aux_pin, dir_core_pin}),
        .sync (dir_sy)
    );

    gpt_edge #(.N(3)) u_cap_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({alt_b_pin, alt_a_pin, cap_pin}),
        .rise (ev_rise),
        .fall (ev_fall)
    );

    always_comb begin
        wr_cc   = wr_en && (wr_addr == A_CORE_CTL);
        wr_ac   = wr_en && (wr_addr == A_AUX_CTL);
        wr_core = wr_en && (wr_addr == A_CORE_CNT);
        wr_aux  = wr_en && (wr_addr == A_AUX_CNT);
        wr_cr   = wr_en && (wr_addr == A_CAPREL);

        core_down = s_q.cc.down ^ (s_q.cc.pin_en & dir_sy[0]);
        aux_down  = s_q.ac.down ^ (s_q.ac.pin_en & dir_sy[1]);

        core_step = s_q.cc.run && tick[0] && !wr_core;
        core_wrap = core_step && (core_down ? (s_q.core == '0) : (&s_q.core));
        aux_step  = s_q.ac.run && (s_q.ac.on_latch ? core_wrap : tick[1]);

        unique case (s_q.ac.src)
            2'b00: begin sel_rise = ev_rise[0];             sel_fall = ev_fall[0];             end
            2'b01: begin sel_rise = ev_rise[1];             sel_fall = ev_fall[1];             end
            2'b10: begin sel_rise = ev_rise[2];             sel_fall = ev_fall[2];             end
            default: begin sel_rise = ev_rise[1] | ev_rise[2]; sel_fall = ev_fall[1] | ev_fall[2]; end
        endcase
        cap_evt = (s_q.ac.edge_sel[0] & sel_rise) | (s_q.ac.edge_sel[1] & sel_fall);
    end

    always_comb begin
        s_d      = s_q;
        s_d.wrap = 1'b0;

        if (wr_cc) s_d.cc = core_ctl_t'(wr_data[CC_W-1:0]);
        if (wr_ac) s_d.ac = aux_ctl_t'(wr_data[AC_W-1:0]);

        if (wr_core) begin
            s_d.core = wr_data;
        end else if (core_step) begin
            if (core_wrap && s_q.cc.reload) s_d.core = s_q.cr;
            else if (core_down)             s_d.core = s_q.core - CNT_W'(1);
            else                            s_d.core = s_q.core + CNT_W'(1);
        end

        if (core_wrap) begin
            s_d.latch = ~s_q.latch;
            s_d.wrap  = 1'b1;
        end

        if (wr_aux) begin
            s_d.aux = wr_data;
        end else if (cap_evt && s_q.ac.clr) begin
            s_d.aux = '0;
        end else if (aux_step) begin
            s_d.aux = aux_down ? s_q.aux - CNT_W'(1) : s_q.aux + CNT_W'(1);
        end

        if (wr_cr)        s_d.cr = wr_data;
        else if (cap_evt) s_d.cr = s_q.aux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign core_cnt   = s_q.core;
    assign aux_cnt    = s_q.aux;
    assign caprel     = s_q.cr;
    assign latch_out  = s_q.latch;
    assign wrap_pulse = s_q.wrap;
    assign chk_reload = s_q.cc.reload;
    assign chk_clr    = s_q.ac.clr;
endmodule

// File: rtl/dual_timer_cr_chk.sv
module dual_timer_cr_chk
    import gpt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  core_cnt,
    input logic [CNT_W-1:0]  aux_cnt,
    input logic [CNT_W-1:0]  caprel,
    input logic              latch_out,
    input logic              wrap_pulse,
    input logic              reload_en,
    input logic              clr_en,
    input logic              cap_evt
);
    p_latch_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (latch_out != $past(latch_out)));

    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap_pulse |-> $stable(latch_out));

    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse);

    p_reload_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_pulse && $past(reload_en)) |-> (core_cnt == $past(caprel)));

    p_core_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_pulse && !$past(wr_en && wr_addr == A_CORE_CNT)) |->
        (core_cnt == $past(core_cnt) || core_cnt == $past(core_cnt) + CNT_W'(1)
         || core_cnt == $past(core_cnt) - CNT_W'(1)));

    p_cap_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && !(wr_en && wr_addr == A_CAPREL)) |=> (caprel == $past(aux_cnt)));

    p_cap_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt && clr_en && !(wr_en && wr_addr == A_AUX_CNT)) |=> (aux_cnt == '0));
endmodule

bind dual_timer_cr dual_timer_cr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .core_cnt  (core_cnt),
    .aux_cnt   (aux_cnt),
    .caprel    (caprel),
    .latch_out (latch_out),
    .wrap_pulse(wrap_pulse),
    .reload_en (chk_reload),
    .clr_en    (chk_clr),
    .cap_evt   (cap_evt)
);

// File: tb/tb_dual_timer_cr.sv
module tb_dual_timer_cr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        dir_core_pin = 1'b0, dir_aux_pin = 1'b0, cap_pin = 1'b0;
    logic        alt_a_pin = 1'b0, alt_b_pin = 1'b0;
    logic [15:0] core_cnt, aux_cnt, caprel;
    logic        latch_out, wrap_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int n_wrap = 0;

    always #4 clk = ~clk;

    dual_timer_cr dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dir_core_pin(dir_core_pin), .dir_aux_pin(dir_aux_pin), .cap_pin(cap_pin),
        .alt_a_pin(alt_a_pin), .alt_b_pin(alt_b_pin),
        .core_cnt(core_cnt), .aux_cnt(aux_cnt), .caprel(caprel),
        .latch_out(latch_out), .wrap_pulse(wrap_pulse)
    );

    always @(negedge clk) if (rst_n && wrap_pulse) n_wrap++;

    typedef struct packed {
        logic [2:0]  code;
        logic        down;
        logic        pin_en;
        logic        pin;
        logic [15:0] start;
        logic [15:0] n;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{3'd0, 1'b0, 1'b0, 1'b0, 16'h0010, 16'd5, 16'h0015, 8'd1},
        '{3'd1, 1'b0, 1'b0, 1'b0, 16'h0100, 16'd3, 16'h0103, 8'd1},
        '{3'd2, 1'b1, 1'b0, 1'b0, 16'h0005, 16'd2, 16'h0003, 8'd3},
        '{3'd0, 1'b0, 1'b0, 1'b0, 16'hFFFE, 16'd3, 16'h0001, 8'd2},
        '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0001, 16'd3, 16'hFFFE, 8'd2},
        '{3'd0, 1'b0, 1'b1, 1'b1, 16'h0010, 16'd4, 16'h000C, 8'd3},
        '{3'd0, 1'b1, 1'b1, 1'b1, 16'h0010, 16'd4, 16'h0014, 8'd3},
        '{3'd0, 1'b0, 1'b1, 1'b0, 16'h0020, 16'd2, 16'h0022, 8'd3},
        '{3'd7, 1'b0, 1'b0, 1'b0, 16'h0000, 16'd1, 16'h0001, 8'd1}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic wait_wrap();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (wrap_pulse) break;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic l0;
        int   w0;
        repeat (3) @(negedge clk);
        check("R12 core", core_cnt, 16'h0);
        check("R12 aux", aux_cnt, 16'h0);
        check("R12 caprel", caprel, 16'h0);
        check("R12 latch", {15'b0, latch_out}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 wrap", {15'b0, wrap_pulse}, 16'h0);

        // R1 R2 R3: table walk on the core timer
        for (int i = 0; i < 9; i++) begin
            int dv;
            dv = 4 << VEC[i].code;
            dir_core_pin = VEC[i].pin;
            wr(3'd0, {11'b0, VEC[i].pin_en, VEC[i].down, 1'b0, VEC[i].code});
            wr(3'd2, VEC[i].start);
            settle();
            wr(3'd0, {11'b0, VEC[i].pin_en, VEC[i].down, 1'b1, VEC[i].code});
            repeat (dv * int'(VEC[i].n) - 2) @(negedge clk);
            wr(3'd0, {11'b0, VEC[i].pin_en, VEC[i].down, 1'b0, VEC[i].code});
            check($sformatf("R%0d table entry %0d", VEC[i].req, i), core_cnt, VEC[i].exp);
        end
        dir_core_pin = 1'b0;

        // R4: one wrap flips latch and gives one pulse
        l0 = latch_out;
        w0 = n_wrap;
        wr(3'd2, 16'hFFFE);
        wr(3'd0, 16'h0008);
        repeat (12 - 2) @(negedge clk);
        wr(3'd0, 16'h0000);
        check("R4 latch flipped", {15'b0, latch_out}, {15'b0, ~l0});
        check("R4 pulse count", 16'(n_wrap - w0), 16'd1);
        check("R4 count after wrap", core_cnt, 16'h0001);

        // R5: reload on wrap
        wr(3'd4, 16'h1234);
        wr(3'd2, 16'hFFFF);
        wr(3'd0, 16'h0048);
        repeat (8 - 2) @(negedge clk);
        wr(3'd0, 16'h0040);
        check("R5 reload then step", core_cnt, 16'h1235);

        // R6: auxiliary counts latch transitions
        wr(3'd3, 16'h0000);
        wr(3'd1, 16'h0048);
        wr(3'd2, 16'hFFFD);
        wr(3'd0, 16'h0008);
        repeat (24 - 2) @(negedge clk);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h0040);
        check("R6 aux latch count", aux_cnt, 16'h0001);

        // R7: edge modes on capture pin, aux stopped
        wr(3'd1, 16'h0080);
        wr(3'd3, 16'h0ABC);
        cap_pin = 1'b1; settle();
        check("R7 rising capture", caprel, 16'h0ABC);
        cap_pin = 1'b0; settle();
        wr(3'd1, 16'h0100);
        wr(3'd3, 16'h0111);
        cap_pin = 1'b1; settle();
        check("R7 rising ignored in falling mode", caprel, 16'h0ABC);
        cap_pin = 1'b0; settle();
        check("R7 falling capture", caprel, 16'h0111);
        wr(3'd1, 16'h0000);
        wr(3'd3, 16'h0222);
        cap_pin = 1'b1; settle();
        cap_pin = 1'b0; settle();
        check("R7 disabled mode ignored", caprel, 16'h0111);
        wr(3'd1, 16'h0180);
        wr(3'd3, 16'h0333);
        cap_pin = 1'b1; settle();
        check("R7 both mode capture", caprel, 16'h0333);

        // R8: clear after capture
        wr(3'd1, 16'h0280);
        cap_pin = 1'b0; settle();
        wr(3'd3, 16'h0444);
        cap_pin = 1'b1; settle();
        check("R8 capture value", caprel, 16'h0444);
        check("R8 aux cleared", aux_cnt, 16'h0000);

        // R9: alternate sources
        wr(3'd1, 16'h0480);
        wr(3'd3, 16'h0555);
        cap_pin = 1'b0; settle();
        cap_pin = 1'b1; settle();
        check("R9 cap pin ignored for source A", caprel, 16'h0444);
        alt_a_pin = 1'b1; settle();
        check("R9 source A", caprel, 16'h0555);
        wr(3'd1, 16'h0880);
        wr(3'd3, 16'h0666);
        alt_a_pin = 1'b0; settle();
        alt_a_pin = 1'b1; settle();
        check("R9 A ignored for source B", caprel, 16'h0555);
        alt_b_pin = 1'b1; settle();
        check("R9 source B", caprel, 16'h0666);
        wr(3'd1, 16'h0C80);
        wr(3'd3, 16'h0777);
        alt_a_pin = 1'b0; alt_b_pin = 1'b0; cap_pin = 1'b0; settle();
        alt_b_pin = 1'b1; settle();
        check("R9 either source", caprel, 16'h0777);

        // R10: capture and reload in the same cycle
        wr(3'd1, 16'h0080);
        wr(3'd3, 16'h2000);
        wr(3'd4, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        wr(3'd0, 16'h0048);
        wait_wrap();
        wait_wrap();
        @(negedge clk);
        cap_pin = 1'b1;
        repeat (2) @(negedge clk);
        wr(3'd0, 16'h0040);
        check("R10 reload used old value", core_cnt, 16'hFFFF);
        check("R10 capture stored", caprel, 16'h2000);

        // R11: write wins over a reload in the same cycle
        wr(3'd1, 16'h0000);
        wr(3'd4, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        wr(3'd0, 16'h0048);
        wait_wrap();
        wait_wrap();
        repeat (2) @(negedge clk);
        wr(3'd2, 16'h5000);
        wr(3'd0, 16'h0040);
        check("R11 write priority", core_cnt, 16'h5000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule